// File: doc/BRIEF.md
# Fetch Next-PC Selector and Predictor

This block sits at the front of a five-stage pipeline for a 64-bit stack-oriented instruction set. It works out the address to fetch from in each cycle and the guess for the address to fetch in the following cycle. The fetch address is not kept in a register of its own. It is chosen by combinational logic at the start of each cycle from three candidates:

- the fall-through address of a conditional jump that reached the memory stage and turned out not taken;
- the return address loaded by a return instruction that reached the write-back stage;
- the guess that was stored in the fetch pipeline register on the previous clock edge.

The guess always assumes that a jump is taken. For a jump or a call, the next address is the target constant taken from the instruction. For every other instruction it is the fetch address plus the length of the instruction, and that length is decoded from the opcode. On every clock edge the guess is stored in the fetch pipeline register. The stages around the block supply their register fields: the opcode, condition flag and carried value of the memory stage, and the opcode and loaded value of the write-back stage. The fetch stage supplies the opcode and the target constant of the instruction just fetched.

Top module: `fetch_pc_sel`

## Requirements
- R1: While `rst_n` is low on a clock edge, the stored guess is set to `RESET_PC`. After reset is released, with no correction active, `fetch_pc` equals `RESET_PC`.
- R2: When `mem_icode` is 7 (conditional jump) and `mem_cnd` is 0, `fetch_pc` equals `mem_vala`.
- R3: When `wb_icode` is 9 (return) and the condition of R2 does not hold, `fetch_pc` equals `wb_valm`.
- R4: When the conditions of R2 and R3 hold in the same cycle, the R2 source wins and `fetch_pc` equals `mem_vala`.
- R5: When neither correction is active, `fetch_pc` equals the value that `pred_pc` had at the previous clock edge taken out of reset.
- R6: A jump in the memory stage with `mem_cnd` = 1 does not redirect the fetch. `fetch_pc` keeps to the R3 or R5 source.
- R7: When `f_icode` is 7 (conditional jump) or 8 (call), `pred_pc` equals `f_valc`.
- R8: For any other `f_icode`, `pred_pc` equals `fetch_pc` plus the instruction length, which is decoded as follows:
  - 2 bytes for opcodes 2, 6, 10 and 11;
  - 10 bytes for opcodes 3, 4 and 5;
  - 1 byte for 0, 1, 9 and for codes 12 to 15.
- R9: A change of the correction inputs changes `fetch_pc` and `pred_pc` in the same cycle, without waiting for a clock edge.
- R10: The fall-through sum wraps modulo 2^`ADDR_W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_icode | input | 4 | Opcode held in the memory-stage register |
| mem_cnd | input | 1 | Condition outcome held in the memory-stage register |
| mem_vala | input | ADDR_W | Carried value of the memory stage (fall-through address for a jump) |
| wb_icode | input | 4 | Opcode held in the write-back-stage register |
| wb_valm | input | ADDR_W | Value loaded from memory, held in the write-back-stage register |
| f_icode | input | 4 | Opcode of the instruction being fetched |
| f_valc | input | ADDR_W | Target constant of the instruction being fetched |
| fetch_pc | output | ADDR_W | Address fetched in this cycle |
| pred_pc | output | ADDR_W | Guess for the next fetch address |

## Verification
The only state in the block is the stored guess. If that state is wrong, `fetch_pc` is wrong in the first cycle after the bad edge in which no correction is active. Because each guess is built from the fetch address before it, the error is carried forward on every later cycle until a correction overrides it. An error in the selection priority or in the length decode shows at once, in the same cycle, on `fetch_pc` or `pred_pc`. The bench therefore compares both outputs every cycle against its own model. It uses random opcodes and random correction events, together with directed cases for the priority tie, a taken jump and wrap-around.

// File: rtl/fpc_pkg.sv
// Package fpc_pkg: opcode codes and widths shared by the fetch next-PC logic.
// Assumes a 4-bit opcode field; codes 12..15 are treated as one-byte forms.
package fpc_pkg;
    localparam int ICODE_W = 4;
    localparam int LEN_W   = 4;

    typedef logic [ICODE_W-1:0] icode_t;

    localparam icode_t IC_HALT  = 4'h0;
    localparam icode_t IC_NOP   = 4'h1;
    localparam icode_t IC_RRMOV = 4'h2;
    localparam icode_t IC_IRMOV = 4'h3;
    localparam icode_t IC_RMMOV = 4'h4;
    localparam icode_t IC_MRMOV = 4'h5;
    localparam icode_t IC_ALU   = 4'h6;
    localparam icode_t IC_JXX   = 4'h7;
    localparam icode_t IC_CALL  = 4'h8;
    localparam icode_t IC_RET   = 4'h9;
    localparam icode_t IC_PUSH  = 4'hA;
    localparam icode_t IC_POP   = 4'hB;
endpackage

// File: rtl/fpc_len_decode.sv
// Module fpc_len_decode: maps an opcode to its instruction length in bytes.
// Assumes a fixed length per opcode; undefined codes decode as one byte.
module fpc_len_decode
    import fpc_pkg::*;
(
    input  icode_t           icode,
    output logic [LEN_W-1:0] len
);
    // Length lookup by opcode class
    always_comb begin
        unique case (icode)
            IC_RRMOV, IC_ALU, IC_PUSH, IC_POP: len = LEN_W'(2);
            IC_IRMOV, IC_RMMOV, IC_MRMOV:      len = LEN_W'(10);
            IC_JXX, IC_CALL:                   len = LEN_W'(9);
            default:                           len = LEN_W'(1);
        endcase
    end
endmodule

// File: rtl/fpc_predictor.sv
// Module fpc_predictor: builds the next-address guess for the fetched opcode.
// Assumes jumps are always taken: jumps and calls guess their target
// constant, all others guess the fall-through address (wraps modulo 2^ADDR_W).
module fpc_predictor
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  icode_t            icode,
    input  logic [ADDR_W-1:0] valc,
    output logic [ADDR_W-1:0] guess
);
    localparam int PAD_W = ADDR_W - LEN_W;

    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] fall_thru;

    fpc_len_decode u_len (
        .icode (icode),
        .len   (len)
    );

    // Fall-through address: current address plus decoded length
    always_comb fall_thru = cur_pc + {{PAD_W{1'b0}}, len};

    // Always-taken policy for control transfers
    always_comb guess = (icode == IC_JXX || icode == IC_CALL) ? valc : fall_thru;
endmodule

// File: rtl/fpc_source_mux.sv
// Module fpc_source_mux: picks the fetch address from the three sources.
// Assumes a not-taken jump in the memory stage outranks a return in write-back.
module fpc_source_mux
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  icode_t            mem_icode,
    input  logic              mem_cnd,
    input  logic [ADDR_W-1:0] mem_vala,
    input  icode_t            wb_icode,
    input  logic [ADDR_W-1:0] wb_valm,
    input  logic [ADDR_W-1:0] held_guess,
    output logic [ADDR_W-1:0] sel_pc
);
    logic mispredict;
    logic ret_done;

    // Correction conditions from the later stages
    always_comb begin
        mispredict = (mem_icode == IC_JXX) && !mem_cnd;
        ret_done   = (wb_icode == IC_RET);
    end

    // Priority select: mispredict, then return, then held guess
    always_comb begin
        if (mispredict)    sel_pc = mem_vala;
        else if (ret_done) sel_pc = wb_valm;
        else               sel_pc = held_guess;
    end
endmodule

// File: rtl/fetch_pc_sel.sv
// Module fetch_pc_sel: fetch-stage next-PC logic. The fetch address is
// chosen combinationally at the start of the cycle; only the guess is stored.
// Assumes the surrounding stage registers present their fields all cycle.
module fetch_pc_sel
    import fpc_pkg::*;
#(
    parameter int              ADDR_W   = 64,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        mem_icode,
    input  logic              mem_cnd,
    input  logic [ADDR_W-1:0] mem_vala,
    input  logic [3:0]        wb_icode,
    input  logic [ADDR_W-1:0] wb_valm,
    input  logic [3:0]        f_icode,
    input  logic [ADDR_W-1:0] f_valc,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] pred_pc
);
    logic [ADDR_W-1:0] guess_q;

    fpc_source_mux #(.ADDR_W(ADDR_W)) u_mux (
        .mem_icode  (mem_icode),
        .mem_cnd    (mem_cnd),
        .mem_vala   (mem_vala),
        .wb_icode   (wb_icode),
        .wb_valm    (wb_valm),
        .held_guess (guess_q),
        .sel_pc     (fetch_pc)
    );

    fpc_predictor #(.ADDR_W(ADDR_W)) u_pred (
        .cur_pc (fetch_pc),
        .icode  (f_icode),
        .valc   (f_valc),
        .guess  (pred_pc)
    );

    // Fetch pipeline register: hold the guess for the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) guess_q <= RESET_PC;
        else        guess_q <= pred_pc;
    end
endmodule

// File: rtl/fpc_checker.sv
// Module fpc_checker: port-level properties for fetch_pc_sel, bound below.
// Assumes the same opcode codes as fpc_pkg.
module fpc_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        mem_icode,
    input logic              mem_cnd,
    input logic [ADDR_W-1:0] mem_vala,
    input logic [3:0]        wb_icode,
    input logic [ADDR_W-1:0] wb_valm,
    input logic [3:0]        f_icode,
    input logic [ADDR_W-1:0] f_valc,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [ADDR_W-1:0] pred_pc
);
    logic past_ok;
    logic misp;
    logic retw;

    // Marks cycles whose previous edge was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        misp = (mem_icode == 4'd7) && !mem_cnd;
        retw = (wb_icode == 4'd9);
    end

    p_mispredict_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        misp |-> fetch_pc == mem_vala);

    p_return_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (retw && !misp) |-> fetch_pc == wb_valm);

    // R4: tie goes to the memory-stage source
    p_tie_priority_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (misp && retw) |-> fetch_pc == mem_vala);

    p_held_guess_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !misp && !retw) |-> fetch_pc == $past(pred_pc));

    p_target_guess_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_icode == 4'd7 || f_icode == 4'd8) |-> pred_pc == f_valc);

    p_nop_fallthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (f_icode == 4'd1) |-> pred_pc == fetch_pc + ADDR_W'(1));
endmodule

bind fetch_pc_sel fpc_checker #(.ADDR_W(ADDR_W)) u_fpc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_icode (mem_icode),
    .mem_cnd   (mem_cnd),
    .mem_vala  (mem_vala),
    .wb_icode  (wb_icode),
    .wb_valm   (wb_valm),
    .f_icode   (f_icode),
    .f_valc    (f_valc),
    .fetch_pc  (fetch_pc),
    .pred_pc   (pred_pc)
);

// File: tb/sim_fetch_pc_sel.sv
// Bench sim_fetch_pc_sel: random and directed stimulus against a bench model.
module sim_fetch_pc_sel;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 64;
    localparam logic [63:0] RST_PC     = 64'h0000_0000_0000_1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    mem_icode = 4'd1;
    logic          mem_cnd = 1'b0;
    logic [AW-1:0] mem_vala = '0;
    logic [3:0]    wb_icode = 4'd1;
    logic [AW-1:0] wb_valm = '0;
    logic [3:0]    f_icode = 4'd1;
    logic [AW-1:0] f_valc = '0;
    logic [AW-1:0] fetch_pc;
    logic [AW-1:0] pred_pc;

    int n_cmp = 0;
    int n_bad = 0;
    logic [AW-1:0] exp_q;
    logic [AW-1:0] exp_fpc;
    logic [AW-1:0] exp_pred;
    bit done = 0;

    fetch_pc_sel #(.ADDR_W(AW), .RESET_PC(RST_PC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .mem_icode(mem_icode), .mem_cnd(mem_cnd), .mem_vala(mem_vala),
        .wb_icode(wb_icode), .wb_valm(wb_valm),
        .f_icode(f_icode), .f_valc(f_valc),
        .fetch_pc(fetch_pc), .pred_pc(pred_pc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Instruction length from the R8 table
    function automatic logic [AW-1:0] len_of(input logic [3:0] ic);
        case (ic)
            4'd2, 4'd6, 4'd10, 4'd11: return 64'd2;
            4'd3, 4'd4, 4'd5:         return 64'd10;
            4'd7, 4'd8:               return 64'd9;
            default:                  return 64'd1;
        endcase
    endfunction

    // Fetch address from R2..R5
    function automatic logic [AW-1:0] model_fpc(input logic [AW-1:0] q);
        if (mem_icode == 4'd7 && !mem_cnd) return mem_vala;
        if (wb_icode == 4'd9)              return wb_valm;
        return q;
    endfunction

    // Guess from R7, R8, R10
    function automatic logic [AW-1:0] model_pred(input logic [AW-1:0] pc);
        if (f_icode == 4'd7 || f_icode == 4'd8) return f_valc;
        return pc + len_of(f_icode);
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    // Compare both outputs with the model in the current cycle
    task automatic check_now(input string req);
        exp_fpc  = model_fpc(exp_q);
        exp_pred = model_pred(exp_fpc);
        check({req, " fetch_pc"}, fetch_pc, exp_fpc);
        check({req, " pred_pc"}, pred_pc, exp_pred);
    endtask

    // Drive after the falling edge, check, then take the rising edge
    task automatic step(input string req, input logic [3:0] mi, input logic mc,
                        input logic [AW-1:0] mv, input logic [3:0] wi,
                        input logic [AW-1:0] wv, input logic [3:0] fi,
                        input logic [AW-1:0] fv);
        @(negedge clk);
        mem_icode = mi; mem_cnd = mc; mem_vala = mv;
        wb_icode = wi; wb_valm = wv; f_icode = fi; f_valc = fv;
        #1;
        check_now(req);
        @(posedge clk);
        exp_q = exp_pred;
    endtask

    function automatic logic [AW-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        void'($urandom(32'd4242));
        exp_q = RST_PC;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_now("R1 reset");

        // R1: first edge out of reset loads a nop fall-through
        @(posedge clk);
        exp_q = exp_pred;
        step("R1 after reset", 4'd1, 1'b0, '0, 4'd1, '0, 4'd2, '0);

        // R2: not-taken jump redirects
        step("R2 mispredict", 4'd7, 1'b0, 64'h2222, 4'd1, 64'h9999, 4'd6, '0);
        // R5: held guess after the redirect
        step("R5 held guess", 4'd1, 1'b0, 64'h5555, 4'd1, 64'h6666, 4'd3, '0);
        // R3: return source
        step("R3 return", 4'd0, 1'b0, 64'h1, 4'd9, 64'h3000, 4'd8, 64'h4000);
        // R7: call target was guessed
        step("R7 call guess", 4'd1, 1'b1, 64'h1, 4'd1, 64'h2, 4'd7, 64'h4444);
        // R4: both corrections at once
        step("R4 tie", 4'd7, 1'b0, 64'h7070, 4'd9, 64'h9090, 4'd1, '0);
        // R6: taken jump in memory stage is ignored
        step("R6 taken jump", 4'd7, 1'b1, 64'hDEAD, 4'd1, '0, 4'd5, '0);
        step("R6 taken jump with return", 4'd7, 1'b1, 64'hBEEF, 4'd9, 64'hCAFE, 4'd4, '0);
        // R10: wrap near the top of the address space
        step("R10 wrap setup", 4'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFFA, 4'd1, '0, 4'd3, '0);
        step("R10 wrapped", 4'd1, 1'b0, '0, 4'd1, '0, 4'd12, '0);

        // R9: outputs follow corrections inside one cycle
        @(negedge clk);
        mem_icode = 4'd1; wb_icode = 4'd1; f_icode = 4'd1; mem_cnd = 1'b0;
        #1;
        check_now("R9 baseline");
        mem_icode = 4'd7; mem_vala = 64'h1234_5678; #1;
        check_now("R9 late mispredict");
        mem_icode = 4'd1; wb_icode = 4'd9; wb_valm = 64'h8765_4321; #1;
        check_now("R9 late return");
        @(posedge clk);
        exp_q = exp_pred;

        // Random mix for R2..R8
        for (int i = 0; i < 400; i++) begin
            logic [3:0] mi;
            logic [3:0] wi;
            mi = ($urandom() % 4 == 0) ? 4'd7 : 4'($urandom());
            wi = ($urandom() % 5 == 0) ? 4'd9 : 4'($urandom());
            step("R2-mix R8 random", mi, 1'($urandom()), rnd64(), wi, rnd64(),
                 4'($urandom()), rnd64());
        end

        // R1: re-entering reset restores the reset address
        @(negedge clk);
        rst_n = 1'b0;
        mem_icode = 4'd1; wb_icode = 4'd1;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_q = RST_PC;
        #1;
        check_now("R1 second reset");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule